// File: doc/BRIEF.md
# Two-tone FSK tag waveform generator

This block turns a 44-bit tag identifier into the one-bit drive level for the coil switch of a low-frequency tag emulator. The waveform uses two subcarrier tones. The short tone has a period of eight samples and the long tone a period of ten samples. Bursts of these tones are arranged into a repeating frame. Every frame starts with a lead cycle and an eight-burst start marker. Each data bit is then sent as a pair of bursts of unequal tone, and a single short-tone spacer cycle comes before each group of four bits.

The output moves one sample forward for each rising edge of an external carrier clock. That clock is synchronized into the system clock domain. Nothing is stored in a buffer: the sample is computed on the fly from a set of counters. These count the sample within a cycle, the cycle within a burst, the element of the frame, and the bit index. A load starts generation, a stop input halts it at the next carrier edge, and a load whose upper word does not fit in 12 bits is refused.

Top module: `fskgen_wavegen`

## Requirements
- R1: After reset, `coil_open` is 0, `running` is 0 and `load_err` is 0.
- R2: A short-tone cycle is 8 samples with levels 1,1,0,0,0,0,0,0. A short burst is 6 such cycles, which is 48 samples.
- R3: A long-tone cycle is 10 samples with levels 1,1,1,0,0,0,0,0,0,0. A long burst is 5 such cycles, which is 50 samples.
- R4: A frame opens with one short-tone cycle. Eight bursts follow, in the tone order short, short, short, long, long, long, short, long.
- R5: Identifier bits are sent from bit 43 down to bit 0. Bits 43..32 come from `id_hi[11:0]` and bits 31..0 come from `id_lo`. A 1 is sent as a long burst and then a short burst. A 0 is sent as a short burst and then a long burst.
- R6: One short-tone cycle is inserted just before every bit whose index modulo 4 equals 3 (bits 43, 39, ..., 3).
- R7: With the default parameters a frame is 4800 samples long. After its last sample, the output continues with sample 0 of the same frame.
- R8: Each rising edge of `carrier_in` seen while running emits exactly one sample. Between edges, `coil_open` holds its value.
- R9: A load with `id_hi` above 0xFFF sets `load_err`, clears `running` and leaves `coil_open` at 0. Later carrier edges produce no waveform.
- R10: If `stop` is high at a carrier edge while running, `running` and `coil_open` go to 0 at that edge. A stop between edges takes no effect until the next edge. While idle, carrier edges leave `coil_open` at 0.
- R11: A valid load clears `load_err`, sets `running`, drives `coil_open` to 0 and restarts the frame at sample 0. This happens even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_in | input | 1 | External carrier clock, asynchronous to `clk` |
| load | input | 1 | One-cycle strobe that captures the identifier |
| id_hi | input | 16 | Upper identifier word; only bits 11:0 are legal |
| id_lo | input | 32 | Lower 32 identifier bits |
| stop | input | 1 | Halts generation at the next carrier edge |
| coil_open | output | 1 | Drive level: 1 opens the coil, 0 shorts it |
| running | output | 1 | Generation in progress |
| load_err | output | 1 | Last load was refused for an oversized upper word |

## Verification
The bench builds the block with its default parameters: a 44-bit identifier, a 16-bit upper input word, tone periods of 8 and 10, and a two-stage synchronizer. With these values, the full 4800-sample frame and its wrap back to sample 0 can be observed within one run. A rejected load needs only an upper word of 0x1000 or more. The frame images that the bench builds on its own expose the start-marker order, the eleven spacer positions and both bit encodings, for directed and seeded random identifiers.

// File: rtl/fskgen_pkg.sv
package fskgen_pkg;

  typedef enum logic [2:0] {
    SEG_LEAD  = 3'd0,
    SEG_SOF   = 3'd1,
    SEG_GAP   = 3'd2,
    SEG_BIT_A = 3'd3,
    SEG_BIT_B = 3'd4
  } seg_e;

  typedef enum logic {
    TONE_SHORT = 1'b0,
    TONE_LONG  = 1'b1
  } tone_e;

  localparam int unsigned SOF_BURSTS = 8;

  // Tone of each burst in the start marker, in transmission order.
  function automatic tone_e sof_tone(input logic [2:0] idx);
    case (idx)
      3'd3, 3'd4, 3'd5, 3'd7: sof_tone = TONE_LONG;
      default:                sof_tone = TONE_SHORT;
    endcase
  endfunction

  // First or second half of a data bit: a 1 goes long then short.
  function automatic tone_e bit_tone(input logic bitv, input logic second);
    bit_tone = (bitv ^ second) ? TONE_LONG : TONE_SHORT;
  endfunction

  // A spacer precedes every bit whose index sits at the top of a nibble.
  function automatic logic needs_gap(input int idx, input int nib);
    needs_gap = (idx >= 0) && ((idx % nib) == (nib - 1));
  endfunction

  // Drive level at a given sample position of a tone cycle.
  function automatic logic tone_level(input tone_e t, input int unsigned samp,
                                      input int unsigned s_hi, input int unsigned l_hi);
    tone_level = samp < ((t == TONE_SHORT) ? s_hi : l_hi);
  endfunction

endpackage

// File: rtl/fskgen_carrier_sync.sv
module fskgen_carrier_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_in,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= carrier_in;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/fskgen_tone_cycle.sv
module fskgen_tone_cycle
  import fskgen_pkg::*;
#(
  parameter int SHORT_PER = 8,
  parameter int SHORT_HI  = 2,
  parameter int LONG_PER  = 10,
  parameter int LONG_HI   = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  adv,
  input  tone_e tone,
  output logic  level,
  output logic  cyc_done,
  output logic [$clog2((SHORT_PER > LONG_PER) ? SHORT_PER : LONG_PER)-1:0] samp_o
);

  localparam int MAX_PER = (SHORT_PER > LONG_PER) ? SHORT_PER : LONG_PER;
  localparam int SAMP_W  = $clog2(MAX_PER);

  logic [SAMP_W-1:0] samp_q;
  logic [SAMP_W-1:0] per_m1;

  always_comb begin
    per_m1   = (tone == TONE_SHORT) ? SAMP_W'(SHORT_PER - 1) : SAMP_W'(LONG_PER - 1);
    cyc_done = (samp_q == per_m1);
    level    = tone_level(tone, 32'(samp_q), SHORT_HI, LONG_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       samp_q <= '0;
    else if (restart) samp_q <= '0;
    else if (adv)     samp_q <= cyc_done ? '0 : samp_q + 1'b1;
  end

  assign samp_o = samp_q;

endmodule

// File: rtl/fskgen_frame_seq.sv
module fskgen_frame_seq
  import fskgen_pkg::*;
#(
  parameter int ID_BITS   = 44,
  parameter int NIB       = 4,
  parameter int SHORT_REP = 6,
  parameter int LONG_REP  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               adv,
  input  logic               cyc_done,
  input  logic [ID_BITS-1:0] id,
  output tone_e              tone,
  output seg_e               seg_o,
  output logic               frame_wrap
);

  localparam int BIT_W   = $clog2(ID_BITS);
  localparam int MAX_REP = (SHORT_REP > LONG_REP) ? SHORT_REP : LONG_REP;
  localparam int CYC_W   = $clog2(MAX_REP + 1);
  localparam int SOF_W   = $clog2(SOF_BURSTS);

  seg_e             seg_q;
  logic [CYC_W-1:0] cyc_q;
  logic [SOF_W-1:0] sof_q;
  logic [BIT_W-1:0] bit_q;

  logic             single;
  logic             cur_bit;
  logic [CYC_W-1:0] reps_m1;
  logic             burst_last;
  logic             elem_done;
  logic             first_gap;
  logic             next_gap;

  always_comb begin
    cur_bit = id[bit_q];
    single  = 1'b0;
    case (seg_q)
      SEG_SOF:   tone = sof_tone(3'(sof_q));
      SEG_BIT_A: tone = bit_tone(cur_bit, 1'b0);
      SEG_BIT_B: tone = bit_tone(cur_bit, 1'b1);
      default: begin
        tone   = TONE_SHORT;
        single = 1'b1;
      end
    endcase
    if (single)                  reps_m1 = '0;
    else if (tone == TONE_SHORT) reps_m1 = CYC_W'(SHORT_REP - 1);
    else                         reps_m1 = CYC_W'(LONG_REP - 1);
    burst_last = (cyc_q == reps_m1);
    elem_done  = adv & cyc_done & burst_last;
    first_gap  = needs_gap(ID_BITS - 1, NIB);
    next_gap   = needs_gap(int'(bit_q) - 1, NIB);
    frame_wrap = elem_done & (seg_q == SEG_BIT_B) & (bit_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_LEAD;
      cyc_q <= '0;
      sof_q <= '0;
      bit_q <= BIT_W'(ID_BITS - 1);
    end else if (restart) begin
      seg_q <= SEG_LEAD;
      cyc_q <= '0;
      sof_q <= '0;
      bit_q <= BIT_W'(ID_BITS - 1);
    end else if (adv && cyc_done) begin
      if (!burst_last) begin
        cyc_q <= cyc_q + 1'b1;
      end else begin
        cyc_q <= '0;
        case (seg_q)
          SEG_LEAD: begin
            seg_q <= SEG_SOF;
            sof_q <= '0;
          end
          SEG_SOF: begin
            if (sof_q != SOF_W'(SOF_BURSTS - 1)) begin
              sof_q <= sof_q + 1'b1;
            end else begin
              bit_q <= BIT_W'(ID_BITS - 1);
              seg_q <= first_gap ? SEG_GAP : SEG_BIT_A;
            end
          end
          SEG_GAP:   seg_q <= SEG_BIT_A;
          SEG_BIT_A: seg_q <= SEG_BIT_B;
          default: begin
            if (bit_q == '0) begin
              seg_q <= SEG_LEAD;
              bit_q <= BIT_W'(ID_BITS - 1);
            end else begin
              bit_q <= bit_q - 1'b1;
              seg_q <= next_gap ? SEG_GAP : SEG_BIT_A;
            end
          end
        endcase
      end
    end
  end

  assign seg_o = seg_q;

endmodule

// File: rtl/fskgen_wavegen.sv
module fskgen_wavegen
  import fskgen_pkg::*;
#(
  parameter int ID_BITS     = 44,
  parameter int LO_W        = 32,
  parameter int HI_IN_W     = 16,
  parameter int NIB         = 4,
  parameter int SHORT_PER   = 8,
  parameter int SHORT_HI    = 2,
  parameter int SHORT_REP   = 6,
  parameter int LONG_PER    = 10,
  parameter int LONG_HI     = 3,
  parameter int LONG_REP    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               carrier_in,
  input  logic               load,
  input  logic [HI_IN_W-1:0] id_hi,
  input  logic [LO_W-1:0]    id_lo,
  input  logic               stop,
  output logic               coil_open,
  output logic               running,
  output logic               load_err
);

  localparam int HI_BITS = ID_BITS - LO_W;
  localparam int MAX_PER = (SHORT_PER > LONG_PER) ? SHORT_PER : LONG_PER;
  localparam int SAMP_W  = $clog2(MAX_PER);

  logic [ID_BITS-1:0] id_q;
  logic               carrier_edge;
  logic               hi_over;
  logic               tick;
  logic               adv;
  logic               stop_hit;
  logic               level;
  logic               cyc_done;
  logic               frame_wrap;
  tone_e              tone;
  seg_e               seg_w;
  logic [SAMP_W-1:0]  samp_w;

  fskgen_carrier_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_in (carrier_in),
    .edge_o     (carrier_edge)
  );

  assign hi_over  = (id_hi >> HI_BITS) != '0;
  assign tick     = carrier_edge & running & ~load;
  assign stop_hit = tick & stop;
  assign adv      = tick & ~stop;

  fskgen_tone_cycle #(
    .SHORT_PER (SHORT_PER),
    .SHORT_HI  (SHORT_HI),
    .LONG_PER  (LONG_PER),
    .LONG_HI   (LONG_HI)
  ) tone_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (load & ~hi_over),
    .adv      (adv),
    .tone     (tone),
    .level    (level),
    .cyc_done (cyc_done),
    .samp_o   (samp_w)
  );

  fskgen_frame_seq #(
    .ID_BITS   (ID_BITS),
    .NIB       (NIB),
    .SHORT_REP (SHORT_REP),
    .LONG_REP  (LONG_REP)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (load & ~hi_over),
    .adv        (adv),
    .cyc_done   (cyc_done),
    .id         (id_q),
    .tone       (tone),
    .seg_o      (seg_w),
    .frame_wrap (frame_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q      <= '0;
      running   <= 1'b0;
      coil_open <= 1'b0;
      load_err  <= 1'b0;
    end else if (load) begin
      coil_open <= 1'b0;
      if (hi_over) begin
        load_err <= 1'b1;
        running  <= 1'b0;
      end else begin
        load_err <= 1'b0;
        running  <= 1'b1;
        id_q     <= {id_hi[HI_BITS-1:0], id_lo};
      end
    end else if (stop_hit) begin
      running   <= 1'b0;
      coil_open <= 1'b0;
    end else if (adv) begin
      coil_open <= level;
    end
  end

endmodule

// File: rtl/fskgen_checker.sv
module fskgen_checker
  import fskgen_pkg::*;
#(
  parameter int SHORT_PER = 8,
  parameter int LONG_PER  = 10,
  parameter int SAMP_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              load,
  input logic              hi_over,
  input logic              stop,
  input logic              running,
  input logic              coil_open,
  input logic              load_err,
  input logic              frame_wrap,
  input seg_e              seg_w,
  input tone_e             tone,
  input logic [SAMP_W-1:0] samp_w
);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(coil_open));

  assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && hi_over) |=> (load_err && !running && !coil_open));

  assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && stop) |=> (!running && !coil_open));

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !coil_open);

  assert_short_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tone == TONE_SHORT) |-> (int'(samp_w) < SHORT_PER));

  assert_long_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tone == TONE_LONG) |-> (int'(samp_w) < LONG_PER));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (seg_w == SEG_LEAD && samp_w == '0));

  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !hi_over) |=> (running && !load_err && seg_w == SEG_LEAD && samp_w == '0));

endmodule

bind fskgen_wavegen fskgen_checker #(
  .SHORT_PER (SHORT_PER),
  .LONG_PER  (LONG_PER),
  .SAMP_W    (SAMP_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .load       (load),
  .hi_over    (hi_over),
  .stop       (stop),
  .running    (running),
  .coil_open  (coil_open),
  .load_err   (load_err),
  .frame_wrap (frame_wrap),
  .seg_w      (seg_w),
  .tone       (tone),
  .samp_w     (samp_w)
);

// File: tb/fskgen_wavegen_tb.sv
module fskgen_wavegen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        carrier_in = 1'b0;
  logic        load = 1'b0;
  logic [15:0] id_hi = '0;
  logic [31:0] id_lo = '0;
  logic        stop = 1'b0;
  logic        coil_open;
  logic        running;
  logic        load_err;

  int checks = 0;
  int bad = 0;
  bit exp_f [0:8191];
  bit act_f [0:8191];
  int exp_len = 0;

  always #10 clk = ~clk;

  fskgen_wavegen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_in (carrier_in),
    .load       (load),
    .id_hi      (id_hi),
    .id_lo      (id_lo),
    .stop       (stop),
    .coil_open  (coil_open),
    .running    (running),
    .load_err   (load_err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add_cycle(input int per, input int hi);
    for (int s = 0; s < per; s++) begin
      exp_f[exp_len] = (s < hi);
      exp_len++;
    end
  endtask

  task automatic add_burst(input bit long_t);
    if (long_t) for (int c = 0; c < 5; c++) add_cycle(10, 3);
    else        for (int c = 0; c < 6; c++) add_cycle(8, 2);
  endtask

  // Expected frame image built from the frame rules (R2..R6).
  task automatic build_frame(input logic [11:0] hi, input logic [31:0] lo);
    logic [43:0] id;
    id = {hi, lo};
    exp_len = 0;
    add_cycle(8, 2);
    add_burst(0); add_burst(0); add_burst(0); add_burst(1);
    add_burst(1); add_burst(1); add_burst(0); add_burst(1);
    for (int b = 43; b >= 0; b--) begin
      if (b % 4 == 3) add_cycle(8, 2);
      if (id[b]) begin add_burst(1); add_burst(0); end
      else       begin add_burst(0); add_burst(1); end
    end
  endtask

  task automatic pulse();
    carrier_in = 1'b1;
    repeat (3) @(negedge clk);
    carrier_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic capture(input int count);
    for (int k = 0; k < count; k++) begin
      pulse();
      act_f[k] = coil_open;
    end
  endtask

  task automatic cmp_range(input int lo, input int hi, input string req);
    int first_bad;
    first_bad = -1;
    for (int k = lo; k < hi; k++)
      if (first_bad < 0 && act_f[k] != exp_f[k % exp_len]) first_bad = k;
    if (first_bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, {first_bad, 7'd0, act_f[first_bad]},
               {first_bad, 7'd0, exp_f[first_bad % exp_len]});
  endtask

  task automatic do_load(input logic [15:0] hi, input logic [31:0] lo);
    id_hi = hi;
    id_lo = lo;
    load  = 1'b1;
    @(negedge clk);
    load  = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 190000; wd++) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=done", wd);
    summary();
  end

  initial begin
    logic [15:0] h;
    logic [31:0] l;
    bit held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(coil_open == 1'b0, "R1 coil", coil_open, 0);
    check(running == 1'b0, "R1 running", running, 0);
    check(load_err == 1'b0, "R1 load_err", load_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: idle edges leave coil shorted
    capture(4);
    check(act_f[0] == 0 && act_f[3] == 0 && !running, "R10 idle", act_f[3], 0);

    // Directed identifier, whole frame plus wrap
    do_load(16'h0A5C, 32'h0F1E_2D3C);
    check(running && !load_err && !coil_open, "R11 load", {running, load_err, coil_open}, 3'b100);
    build_frame(12'hA5C, 32'h0F1E_2D3C);
    check(exp_len == 4800, "R7 length", exp_len, 4800);
    capture(4820);
    cmp_range(0, 8, "R2 lead cycle");
    cmp_range(8, 152, "R2 short bursts");
    cmp_range(152, 302, "R3 long bursts");
    cmp_range(0, 400, "R4 header");
    cmp_range(400, 408, "R6 first spacer");
    cmp_range(408, 4800, "R5 data");
    cmp_range(4800, 4820, "R7 wrap");
    // R8: output holds between edges
    held = coil_open;
    repeat (15) @(negedge clk);
    check(coil_open == held, "R8 hold", coil_open, held);

    // Random identifiers, partial frames
    for (int r = 0; r < 3; r++) begin
      h = 16'($urandom % 4096);
      l = $urandom;
      do_load(h, l);
      build_frame(h[11:0], l);
      capture(700);
      cmp_range(0, 700, "R5 random");
    end

    // R11: reload in mid frame restarts at sample 0
    h = 16'($urandom % 4096);
    l = $urandom;
    do_load(h, l);
    build_frame(h[11:0], l);
    capture(300);
    do_load(16'h0FFF, 32'hFFFF_FFFF);
    build_frame(12'hFFF, 32'hFFFF_FFFF);
    capture(600);
    cmp_range(0, 600, "R11 restart");

    // R10: stop waits for the next edge, then shorts the coil
    stop = 1'b1;
    repeat (10) @(negedge clk);
    check(running == 1'b1, "R10 wait for edge", running, 1);
    pulse();
    check(!running && !coil_open, "R10 stop", {running, coil_open}, 0);
    stop = 1'b0;
    capture(5);
    check(act_f[4] == 0 && !running, "R10 stays idle", act_f[4], 0);

    // R9: oversized upper word is refused
    do_load(16'h0123, 32'h5555_AAAA);
    capture(2);
    h = 16'h1000 + 16'($urandom % 16'hF000);
    do_load(h, 32'h1234_5678);
    check(load_err && !running && !coil_open, "R9 reject", {load_err, running, coil_open}, 3'b100);
    capture(20);
    check(act_f[19] == 0 && act_f[0] == 0 && !running, "R9 no wave", act_f[19], 0);
    do_load(16'h1000, 32'h0);
    check(load_err == 1'b1, "R9 boundary", load_err, 1);

    // R11: valid load clears the error
    do_load(16'h0FFF, 32'h0000_0001);
    check(!load_err && running, "R11 clear err", {load_err, running}, 2'b01);
    build_frame(12'hFFF, 32'h0000_0001);
    capture(408);
    cmp_range(0, 408, "R4 header max id");
    summary();
  end

endmodule